// File: doc/BRIEF.md
# Low-power oscillator calibration counters

This block measures how fast a slow, untrimmed low-power oscillator runs compared with an accurate reference clock, so that software can work out a trim value. A window counter in the reference domain counts from zero up to its all-ones value, which fixes a measurement window of a known number of reference periods. While the window is open, a second counter in the low-power domain counts oscillator edges. When the window closes, the block freezes that count, copies both counts into readable value registers in the system clock domain and raises a done flag.

Three clock domains are involved. The control inputs and all readable state live on the system clock `clk`. The window counter runs on `ref_clk` and the edge counter on `lp_clk`. Every control level that crosses domains goes through a multi-flop synchroniser, and so do the window, completion and activity indications that come back. The multi-bit counts are copied into the system domain only after the source counter has provably stopped. The block also supplies a divide-by-four copy of the low-power oscillator as the time base for the watchdog and wake-up timers.

Top module: `lposc_cal`

## Requirements
- R1: After `rst_n` is released, `done`, `ovf`, `ref_val` and `lp_val` all read zero.
- R2: With `cal_en` high and the block idle, a measurement starts. The window lasts 2^REF_W `ref_clk` periods, counted from 0 up to all ones (511 by default). At the end, `done` goes to 1 and `ref_val` reads all ones.
- R3: At completion, `lp_val` holds the number of `lp_clk` rising edges inside the window, within ±2 of 2^REF_W × T_ref / T_lp. `lp_val` is captured only after the edge counter has stopped.
- R4: `done`, `ref_val` and `lp_val` hold their values while `cal_en` stays high. When `cal_en` is cleared after completion, `done` returns to 0 within a few `clk` cycles and the value registers keep their contents.
- R5: If `cal_en` is cleared before completion, the measurement is aborted. `done` is not raised for that attempt, and the value registers keep their previous contents. A later `cal_en` runs a normal measurement.
- R6: A high `clr_ref` zeroes `ref_val` only, and a high `clr_lp` zeroes `lp_val` only. A clear wins over a capture in the same cycle.
- R7: The edge count saturates at 2^LP_W−1 (1023). `ovf` reads 1 when more than 1023 edges fell in the window, and it is cleared when the next measurement starts.
- R8: A high `cal_rst` zeroes `done`, `ovf`, `ref_val` and `lp_val` on the next `clk` edge and resets both counters. No measurement starts again until `cal_rst` is low and `cal_en` has been seen low.
- R9: `lp_div_clk` is `lp_clk` divided by 4 (two periods high, two low). It runs whatever the calibration state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for control inputs and readable state |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised into each domain |
| ref_clk | input | 1 | Accurate reference clock |
| lp_clk | input | 1 | Low-power oscillator clock under measurement |
| cal_en | input | 1 | Calibration enable: high starts, low aborts or releases |
| cal_rst | input | 1 | Calibration reset: clears results and counters, disables until re-enabled |
| clr_ref | input | 1 | Clears the reference count value register |
| clr_lp | input | 1 | Clears the oscillator count value register |
| done | output | 1 | Measurement complete |
| ovf | output | 1 | Oscillator count saturated in the last measurement |
| ref_val | output | REF_W | Captured reference window count |
| lp_val | output | LP_W | Captured oscillator edge count |
| lp_div_clk | output | 1 | Low-power oscillator divided by four |

## Verification
The bench measures at three oscillator periods, including one fast enough to saturate the edge counter. A design that captured the count before the low-power domain stopped, or that got the window length wrong, would report an edge count outside the ±2 band. It aborts a measurement midway and pulses the reset mid-window with the enable still held. A design with a leaky abort path would raise a spurious done or overwrite the stored results, and one that ignored the reset hold-off would restart on its own. The bench also issues each clear alone to catch crossed clear bits. It runs a clean measurement after the saturating one, which exposes an overflow flag that never clears.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_SETTLE = 3'd2,
    ST_DONE   = 3'd3,
    ST_DRAIN  = 3'd4
  } cal_state_e;
endpackage

// File: rtl/cal_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser, also used as reset synchroniser (d tied high).
module cal_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cal_ref_win.sv
`timescale 1ns/1ps
// Reference domain: opens a window of 2^REF_W reference periods.
module cal_ref_win #(
  parameter int REF_W       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_in,
  input  logic             wipe_in,
  output logic             win,
  output logic             fin,
  output logic             busy,
  output logic [REF_W-1:0] cnt
);
  localparam logic [REF_W-1:0] CNT_MAX = '1;

  logic go_s, wipe_s, armed;

  cal_sync #(.W(2), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk(clk), .rst_n(rst_n), .d({wipe_in, go_in}), .q({wipe_s, go_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      win   <= 1'b0;
      fin   <= 1'b0;
      armed <= 1'b1;
    end else if (!go_s) begin
      win   <= 1'b0;
      fin   <= 1'b0;
      armed <= 1'b1;
      if (wipe_s) cnt <= '0;
    end else if (wipe_s) begin
      cnt <= '0;
      win <= 1'b0;
      fin <= 1'b0;
    end else if (armed) begin
      cnt   <= '0;
      win   <= 1'b1;
      armed <= 1'b0;
    end else if (win) begin
      if (cnt == CNT_MAX) begin
        win <= 1'b0;
        fin <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign busy = ~armed;

  // R2
  win_fin_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(win && fin));
  // R2
  fin_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin) |-> cnt == CNT_MAX);
endmodule

// File: rtl/cal_lp_cnt.sv
`timescale 1ns/1ps
// Low-power domain: counts oscillator edges while the window is seen open,
// saturating, and divides the oscillator for the timers.
module cal_lp_cnt #(
  parameter int LP_W        = 10,
  parameter int SYNC_STAGES = 2,
  parameter int LP_DIV      = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            win_in,
  input  logic            wipe_in,
  output logic [LP_W-1:0] cnt,
  output logic            ovf,
  output logic            act,
  output logic            div_clk
);
  localparam int              DIV_W   = $clog2(LP_DIV);
  localparam logic [LP_W-1:0] CNT_MAX = '1;
  localparam logic [LP_W-1:0] CNT_ONE = LP_W'(1);

  logic             win_s, wipe_s;
  logic [DIV_W-1:0] div_q;

  cal_sync #(.W(2), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk(clk), .rst_n(rst_n), .d({wipe_in, win_in}), .q({wipe_s, win_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ovf   <= 1'b0;
      act   <= 1'b0;
      div_q <= '0;
    end else begin
      act   <= win_s;
      div_q <= div_q + 1'b1;
      if (wipe_s) begin
        cnt <= '0;
        ovf <= 1'b0;
      end else if (win_s && !act) begin
        cnt <= CNT_ONE;
        ovf <= 1'b0;
      end else if (win_s) begin
        if (cnt == CNT_MAX) ovf <= 1'b1;
        else                cnt <= cnt + 1'b1;
      end
    end
  end

  assign div_clk = div_q[DIV_W-1];

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> cnt == CNT_MAX);
  // R3
  frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_s && !act && !wipe_s) |=> $stable(cnt));
endmodule

// File: rtl/cal_ctrl.sv
`timescale 1ns/1ps
// System domain: sequencing, result capture, clears and reset hold-off.
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int REF_W       = 9,
  parameter int LP_W        = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_en,
  input  logic             cal_rst,
  input  logic             clr_ref,
  input  logic             clr_lp,
  input  logic             fin_in,
  input  logic             ref_busy_in,
  input  logic             lp_act_in,
  input  logic [REF_W-1:0] ref_cnt,
  input  logic [LP_W-1:0]  lp_cnt,
  input  logic             lp_ovf,
  output logic             go,
  output logic             wipe,
  output logic             done,
  output logic             ovf,
  output logic [REF_W-1:0] ref_val,
  output logic [LP_W-1:0]  lp_val
);
  localparam logic [REF_W-1:0] REF_MAX = '1;

  cal_state_e st, st_n;
  logic fin_s, busy_s, act_s, need_low;

  cal_sync #(.W(3), .STAGES(SYNC_STAGES)) u_back_sync (
    .clk(clk), .rst_n(rst_n),
    .d({fin_in, ref_busy_in, lp_act_in}), .q({fin_s, busy_s, act_s})
  );

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE:   if (cal_en && !need_low) st_n = ST_RUN;
      ST_RUN:    if (!cal_en) st_n = ST_DRAIN;
                 else if (fin_s) st_n = ST_SETTLE;
      ST_SETTLE: if (!cal_en) st_n = ST_DRAIN;
                 else if (!act_s) st_n = ST_DONE;
      ST_DONE:   if (!cal_en) st_n = ST_DRAIN;
      ST_DRAIN:  if (!fin_s && !busy_s && !act_s) st_n = ST_IDLE;
      default:   st_n = ST_DRAIN;
    endcase
    if (cal_rst) st_n = ST_DRAIN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      go       <= 1'b0;
      wipe     <= 1'b0;
      done     <= 1'b0;
      ovf      <= 1'b0;
      need_low <= 1'b0;
      ref_val  <= '0;
      lp_val   <= '0;
    end else begin
      st   <= st_n;
      go   <= (st_n == ST_RUN) || (st_n == ST_SETTLE) || (st_n == ST_DONE);
      done <= (st_n == ST_DONE);
      if (cal_rst)      need_low <= 1'b1;
      else if (!cal_en) need_low <= 1'b0;
      if (cal_rst) begin
        wipe    <= 1'b1;
        ovf     <= 1'b0;
        ref_val <= '0;
        lp_val  <= '0;
      end else begin
        if (st == ST_IDLE && st_n == ST_RUN) begin
          wipe <= 1'b0;
          ovf  <= 1'b0;
        end
        if (st == ST_SETTLE && st_n == ST_DONE) begin
          ref_val <= ref_cnt;
          lp_val  <= lp_cnt;
          ovf     <= lp_ovf;
        end
        if (clr_ref) ref_val <= '0;
        if (clr_lp)  lp_val  <= '0;
      end
    end
  end

  // R8
  crst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_rst |=> (!done && !ovf && ref_val == '0 && lp_val == '0));
  // R2
  done_full_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !$past(clr_ref)) |-> ref_val == REF_MAX);
  // R5
  no_done_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_en |=> !$rose(done));
endmodule

// File: rtl/lposc_cal.sv
`timescale 1ns/1ps
module lposc_cal #(
  parameter int REF_W       = 9,
  parameter int LP_W        = 10,
  parameter int SYNC_STAGES = 2,
  parameter int LP_DIV      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic             lp_clk,
  input  logic             cal_en,
  input  logic             cal_rst,
  input  logic             clr_ref,
  input  logic             clr_lp,
  output logic             done,
  output logic             ovf,
  output logic [REF_W-1:0] ref_val,
  output logic [LP_W-1:0]  lp_val,
  output logic             lp_div_clk
);
  logic             ref_rst_n, lp_rst_n;
  logic             go, wipe, win, fin, ref_busy, lp_act, lp_ovf;
  logic [REF_W-1:0] ref_cnt;
  logic [LP_W-1:0]  lp_cnt;

  cal_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ref_rst (
    .clk(ref_clk), .rst_n(rst_n), .d(1'b1), .q(ref_rst_n)
  );
  cal_sync #(.W(1), .STAGES(SYNC_STAGES)) u_lp_rst (
    .clk(lp_clk), .rst_n(rst_n), .d(1'b1), .q(lp_rst_n)
  );

  cal_ctrl #(.REF_W(REF_W), .LP_W(LP_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .cal_rst(cal_rst),
    .clr_ref(clr_ref), .clr_lp(clr_lp), .fin_in(fin), .ref_busy_in(ref_busy),
    .lp_act_in(lp_act), .ref_cnt(ref_cnt), .lp_cnt(lp_cnt), .lp_ovf(lp_ovf),
    .go(go), .wipe(wipe), .done(done), .ovf(ovf),
    .ref_val(ref_val), .lp_val(lp_val)
  );

  cal_ref_win #(.REF_W(REF_W), .SYNC_STAGES(SYNC_STAGES)) u_ref (
    .clk(ref_clk), .rst_n(ref_rst_n), .go_in(go), .wipe_in(wipe),
    .win(win), .fin(fin), .busy(ref_busy), .cnt(ref_cnt)
  );

  cal_lp_cnt #(.LP_W(LP_W), .SYNC_STAGES(SYNC_STAGES), .LP_DIV(LP_DIV)) u_lp (
    .clk(lp_clk), .rst_n(lp_rst_n), .win_in(win), .wipe_in(wipe),
    .cnt(lp_cnt), .ovf(lp_ovf), .act(lp_act), .div_clk(lp_div_clk)
  );
endmodule

// File: tb/sim_lposc_cal.sv
`timescale 1ns/1ps
module sim_lposc_cal;
  localparam int REF_HALF = 50;
  localparam int WIN_LEN  = 512;
  localparam int LP_MAX   = 1023;

  typedef struct {
    int lo;
    int hi;
    bit ovf_e;
  } exp_t;

  logic       clk = 1'b0, ref_clk = 1'b0, lp_clk = 1'b0;
  logic       rst_n = 1'b0, cal_en = 1'b0, cal_rst = 1'b0;
  logic       clr_ref = 1'b0, clr_lp = 1'b0;
  logic       done, ovf, lp_div_clk;
  logic [8:0] ref_val;
  logic [9:0] lp_val;
  int         lp_half = 75;
  int         total = 0, bad = 0;
  exp_t       sb[$];
  exp_t       e;
  logic       done_q = 1'b0;

  always #10 clk = ~clk;
  always #(REF_HALF) ref_clk = ~ref_clk;
  always begin #(lp_half) lp_clk = ~lp_clk; end

  lposc_cal u0 (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .lp_clk(lp_clk),
    .cal_en(cal_en), .cal_rst(cal_rst), .clr_ref(clr_ref), .clr_lp(clr_lp),
    .done(done), .ovf(ovf), .ref_val(ref_val), .lp_val(lp_val),
    .lp_div_clk(lp_div_clk)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each completion
  always @(negedge clk) begin
    if (rst_n && done && !done_q) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R5 unexpected done", 1, 0);
      end else begin
        e = sb.pop_front();
        chk(ref_val == 9'h1FF, "R2 ref window count", int'(ref_val), 511);
        chk(int'(lp_val) >= e.lo && int'(lp_val) <= e.hi, "R3 lp edge count",
            int'(lp_val), (e.lo + e.hi) / 2);
        chk(ovf == e.ovf_e, "R7 overflow flag", int'(ovf), int'(e.ovf_e));
      end
    end
    done_q = done;
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver: pushes the expectation, runs one measurement, then releases
  task automatic measure(input int half);
    exp_t x;
    int   nom, waited;
    logic [9:0] held;
    lp_half = half;
    cycles(20);
    nom = (WIN_LEN * 2 * REF_HALF) / (2 * half);
    x.lo = nom - 2; x.hi = nom + 2; x.ovf_e = 1'b0;
    if (x.lo > LP_MAX) begin x.lo = LP_MAX; x.hi = LP_MAX; x.ovf_e = 1'b1; end
    sb.push_back(x);
    cal_en = 1'b1;
    waited = 0;
    while (!done && waited < 20000) begin @(negedge clk); waited++; end
    chk(done == 1'b1, "R2 done raised", int'(done), 1);
    cycles(50);
    chk(done == 1'b1, "R4 done held while enabled", int'(done), 1);
    chk(ref_val == 9'h1FF, "R4 ref value held", int'(ref_val), 511);
    held = lp_val;
    cal_en = 1'b0;
    cycles(6);
    chk(done == 1'b0, "R4 done drops on release", int'(done), 0);
    chk(lp_val == held, "R4 lp value kept on release", int'(lp_val), int'(held));
    cycles(40);
  endtask

  task automatic div_chk(input string why);
    bit s[24];
    bit ok;
    ok = 1'b1;
    for (int i = 0; i < 24; i++) begin @(negedge lp_clk); s[i] = lp_div_clk; end
    for (int i = 4; i < 24; i++) if (s[i] != s[i-4] || s[i] == s[i-2]) ok = 1'b0;
    chk(ok, why, int'(ok), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [9:0] sv_lp;
    cycles(5);
    rst_n = 1'b1;
    cycles(30);
    // R1 reset state
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    chk(ovf == 1'b0, "R1 ovf after reset", int'(ovf), 0);
    chk(ref_val == 9'd0, "R1 ref_val after reset", int'(ref_val), 0);
    chk(lp_val == 10'd0, "R1 lp_val after reset", int'(lp_val), 0);
    div_chk("R9 divide by four while idle");

    measure(75);
    // R6 separate clears
    clr_lp = 1'b1; @(negedge clk); clr_lp = 1'b0;
    chk(lp_val == 10'd0, "R6 clr_lp zeroes lp_val", int'(lp_val), 0);
    chk(ref_val == 9'h1FF, "R6 clr_lp leaves ref_val", int'(ref_val), 511);
    clr_ref = 1'b1; @(negedge clk); clr_ref = 1'b0;
    chk(ref_val == 9'd0, "R6 clr_ref zeroes ref_val", int'(ref_val), 0);

    measure(30);
    div_chk("R9 divide by four at a faster oscillator");

    // R5 abort mid-window
    sv_lp = lp_val;
    cal_en = 1'b1;
    cycles(1000);
    cal_en = 1'b0;
    cycles(4000);
    chk(done == 1'b0, "R5 no done after abort", int'(done), 0);
    chk(lp_val == sv_lp, "R5 lp_val kept after abort", int'(lp_val), int'(sv_lp));
    chk(ref_val == 9'h1FF, "R5 ref_val kept after abort", int'(ref_val), 511);

    measure(20);   // R7 saturation
    measure(75);   // R7 flag cleared by the next start

    // R8 calibration reset mid-window with enable held
    cal_en = 1'b1;
    cycles(1000);
    cal_rst = 1'b1;
    cycles(3);
    cal_rst = 1'b0;
    chk(done == 1'b0, "R8 done cleared", int'(done), 0);
    chk(ovf == 1'b0, "R8 ovf cleared", int'(ovf), 0);
    chk(ref_val == 9'd0, "R8 ref_val cleared", int'(ref_val), 0);
    chk(lp_val == 10'd0, "R8 lp_val cleared", int'(lp_val), 0);
    cycles(6000);
    chk(done == 1'b0, "R8 no restart while enable held", int'(done), 0);
    cal_en = 1'b0;
    cycles(10);
    measure(75);

    chk(sb.size() == 0, "R2 all measurements completed", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule